// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the register face of a byte-oriented serial port. A host reaches it over a single-cycle 32-bit word bus with a 12-bit address. A word write to the data-out location sends the low byte of the write data out as a one-cycle valid/data pulse. Incoming bytes arrive on a valid/data stream with a ready signal. They land in a status word together with a data-available flag and two transmitter flags.

Interrupts are kept as a raw register, a mask and a derived masked view, and a single level output is driven from them. Raw bits are cleared through a write-one-to-clear acknowledge location. That location never holds a value. There is one exception to the clearing rule: while a transmitted byte has not yet been acknowledged, acknowledging the transmit bit re-arms it once instead of clearing it. The status word can be read at two offsets. One of them clears the data-available flag as a side effect, and the other only observes.

Only word accesses act. Byte-wide reads return zero and byte-wide writes do nothing. Bit serialization, baud timing and DMA belong to other blocks.

Top module: `serRegFront`

## Requirements
- R1: After reset, a read of the status word returns 0x0140_0000: transmitter ready at bit 24 and transmitter idle at bit 22 are set, and every other bit is clear. The raw and masked interrupt registers read 0, the interrupt output is low, no transmit pulse is present and rxReady is high. Bits 24 and 22 stay set afterwards.
- R2: The transmit control (0x000), transmit DMA enable (0x004), receive control (0x008) and interrupt mask (0x02C) registers each read back the last 32-bit word written to them.
- R3: A word write to offset 0x01C drives txValid high for exactly the one cycle after the write edge, with txData equal to write data bits 7:0. The same write sets raw interrupt bit 0 and marks a transmit as pending.
- R4: A word read at 0x020 returns the status word and then clears the data-available flag (status bit 16). A word read at 0x024 returns the same word and changes nothing.
- R5: rxReady is high when receive control bit 0 is set or raw interrupt bit 3 is clear. A byte offered while rxReady is high replaces status bits 7:0 and sets status bit 16 and raw interrupt bit 3. A byte offered while rxReady is low changes nothing.
- R6: Writing a word to the acknowledge offset 0x030 clears every raw interrupt bit that is 1 in the written word. A read of 0x030 always returns 0.
- R7: If a transmit is pending and an acknowledge write has bit 0 set, raw bit 0 is set rather than cleared and the pending mark is dropped. A later acknowledge of bit 0 then clears it.
- R8: A read of 0x038 returns raw AND mask (raw is read at 0x034). The irq output is high exactly when that value is nonzero, and it follows any register write or received byte by one clock.
- R9: A byte-wide read returns 0 at any offset. A byte-wide write changes no register and emits no transmit byte.
- R10: A word read of an offset outside the map, or of the data-out offset, returns 0. A word write to the raw or masked interrupt offsets, to either status offset or outside the map changes no state.
- R11: When a byte is accepted in the same cycle as a clearing status read or an acknowledge of bit 3, the accepted byte wins: status bit 16 and raw bit 3 end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWord | input | 1 | 1 = 32-bit word access, 0 = byte access |
| busAddr | input | 12 | Byte offset within the block |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| txValid | output | 1 | Transmit byte present (one-cycle pulse) |
| txData | output | 8 | Transmit byte |
| rxValid | input | 1 | Receive byte offered |
| rxData | input | 8 | Receive byte |
| rxReady | output | 1 | Receive byte will be taken this cycle |
| irq | output | 1 | Level interrupt |

## Verification
The hardest cases to reach from the ports are those where two agents touch the same bit in one cycle. In the first, an incoming byte meets a clearing status read. In the second, an incoming byte meets an acknowledge of the receive interrupt. The bench drives the bus access and the receive stream on the same falling edge. It first opens rxReady, either by clearing raw bit 3 or by setting receive control bit 0, so that both actions land on the same rising edge. It then observes the outcome through the non-clearing status alias and the raw register. The pending-transmit re-arm rule is reached with two acknowledge writes after a single data-out write. The first acknowledge must leave raw bit 0 set and the second must clear it.

// File: rtl/serRegPkg.sv
package serRegPkg;
  parameter int ADDR_W = 12;
  parameter int DATA_W = 32;
  parameter int BYTE_W = 8;

  localparam int DAV_BIT     = 16;
  localparam int TX_IDLE_BIT = 22;
  localparam int TX_RDY_BIT  = 24;
  localparam int TX_INT_BIT  = 0;
  localparam int RX_INT_BIT  = 3;

  localparam logic [ADDR_W-1:0] OFF_TX_CTRL  = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] OFF_DMA_EN   = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] OFF_REC_CTRL = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] OFF_DOUT     = ADDR_W'('h01C);
  localparam logic [ADDR_W-1:0] OFF_STAT_CLR = ADDR_W'('h020);
  localparam logic [ADDR_W-1:0] OFF_STAT_OBS = ADDR_W'('h024);
  localparam logic [ADDR_W-1:0] OFF_MASK     = ADDR_W'('h02C);
  localparam logic [ADDR_W-1:0] OFF_ACK      = ADDR_W'('h030);
  localparam logic [ADDR_W-1:0] OFF_RAW      = ADDR_W'('h034);
  localparam logic [ADDR_W-1:0] OFF_MASKED   = ADDR_W'('h038);

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TXCTRL, SEL_DMAEN, SEL_RECCTRL,
    SEL_STAT, SEL_MASK, SEL_RAW, SEL_MASKED
  } rdSelT;

  typedef struct packed {
    logic wrTxCtrl;
    logic wrDmaEn;
    logic wrRecCtrl;
    logic wrDout;
    logic wrMask;
    logic wrAck;
    logic rdStatClr;
    logic rxAccept;
  } strobeT;
endpackage

// File: rtl/serRegCtrl.sv
module serRegCtrl
  import serRegPkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busWord,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rxValid,
  input  logic              rxReady,
  output strobeT            strb,
  output rdSelT             rdSel
);
  logic wordWr;
  logic wordRd;

  assign wordWr = busSel & busWrite & busWord;
  assign wordRd = busSel & ~busWrite & busWord;

  always_comb begin
    strb  = '0;
    rdSel = SEL_NONE;
    if (wordWr) begin
      case (busAddr)
        OFF_TX_CTRL:  strb.wrTxCtrl  = 1'b1;
        OFF_DMA_EN:   strb.wrDmaEn   = 1'b1;
        OFF_REC_CTRL: strb.wrRecCtrl = 1'b1;
        OFF_DOUT:     strb.wrDout    = 1'b1;
        OFF_MASK:     strb.wrMask    = 1'b1;
        OFF_ACK:      strb.wrAck     = 1'b1;
        default:      ;
      endcase
    end
    if (wordRd) begin
      case (busAddr)
        OFF_TX_CTRL:  rdSel = SEL_TXCTRL;
        OFF_DMA_EN:   rdSel = SEL_DMAEN;
        OFF_REC_CTRL: rdSel = SEL_RECCTRL;
        OFF_STAT_CLR: begin
          rdSel          = SEL_STAT;
          strb.rdStatClr = 1'b1;
        end
        OFF_STAT_OBS: rdSel = SEL_STAT;
        OFF_MASK:     rdSel = SEL_MASK;
        OFF_RAW:      rdSel = SEL_RAW;
        OFF_MASKED:   rdSel = SEL_MASKED;
        default:      rdSel = SEL_NONE;
      endcase
    end
    strb.rxAccept = rxValid & rxReady;
  end
endmodule

// File: rtl/serRegData.sv
module serRegData
  import serRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  rdSelT             rdSel,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] rxData,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  output logic              rxReady,
  output logic              irq,
  output logic [DATA_W-1:0] rawIntr,
  output logic              davFlag,
  output logic              txPending
);
  logic [DATA_W-1:0] txCtrlQ, dmaEnQ, recCtrlQ, maskQ, rawQ;
  logic [BYTE_W-1:0] rxByteQ, txDataQ;
  logic              davQ, pendQ, txValidQ, txRdyQ, txIdleQ;

  logic [DATA_W-1:0] rawN, ackBits, statWord, maskedW;
  logic [BYTE_W-1:0] rxByteN;
  logic              davN, pendN;

  // next state of interrupt, pending and receive capture
  always_comb begin
    rawN    = rawQ;
    pendN   = pendQ;
    davN    = davQ;
    rxByteN = rxByteQ;
    ackBits = '0;
    if (strb.wrDout) begin
      rawN[TX_INT_BIT] = 1'b1;
      pendN            = 1'b1;
    end
    if (strb.wrAck) begin
      ackBits = busWdata;
      if (pendQ && busWdata[TX_INT_BIT]) begin
        ackBits[TX_INT_BIT] = 1'b0;
        rawN[TX_INT_BIT]    = 1'b1;
        pendN               = 1'b0;
      end
      rawN = rawN & ~ackBits;
    end
    if (strb.rdStatClr) davN = 1'b0;
    if (strb.rxAccept) begin
      rawN[RX_INT_BIT] = 1'b1;
      rxByteN          = rxData;
      davN             = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCtrlQ  <= '0;
      dmaEnQ   <= '0;
      recCtrlQ <= '0;
      maskQ    <= '0;
      rawQ     <= '0;
      rxByteQ  <= '0;
      txDataQ  <= '0;
      davQ     <= 1'b0;
      pendQ    <= 1'b0;
      txValidQ <= 1'b0;
      txRdyQ   <= 1'b1;
      txIdleQ  <= 1'b1;
    end else begin
      if (strb.wrTxCtrl)  txCtrlQ  <= busWdata;
      if (strb.wrDmaEn)   dmaEnQ   <= busWdata;
      if (strb.wrRecCtrl) recCtrlQ <= busWdata;
      if (strb.wrMask)    maskQ    <= busWdata;
      if (strb.wrDout)    txDataQ  <= busWdata[BYTE_W-1:0];
      txValidQ <= strb.wrDout;
      rawQ     <= rawN;
      pendQ    <= pendN;
      davQ     <= davN;
      rxByteQ  <= rxByteN;
    end
  end

  always_comb begin
    statWord                = '0;
    statWord[BYTE_W-1:0]    = rxByteQ;
    statWord[DAV_BIT]       = davQ;
    statWord[TX_IDLE_BIT]   = txIdleQ;
    statWord[TX_RDY_BIT]    = txRdyQ;
  end

  assign maskedW = rawQ & maskQ;

  always_comb begin
    case (rdSel)
      SEL_TXCTRL:  busRdata = txCtrlQ;
      SEL_DMAEN:   busRdata = dmaEnQ;
      SEL_RECCTRL: busRdata = recCtrlQ;
      SEL_STAT:    busRdata = statWord;
      SEL_MASK:    busRdata = maskQ;
      SEL_RAW:     busRdata = rawQ;
      SEL_MASKED:  busRdata = maskedW;
      default:     busRdata = '0;
    endcase
  end

  assign rxReady   = recCtrlQ[0] | ~rawQ[RX_INT_BIT];
  assign irq       = |maskedW;
  assign txValid   = txValidQ;
  assign txData    = txDataQ;
  assign rawIntr   = rawQ;
  assign davFlag   = davQ;
  assign txPending = pendQ;
endmodule

// File: rtl/serRegFront.sv
module serRegFront
  import serRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busWord,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxReady,
  output logic              irq
);
  strobeT            strb;
  rdSelT             rdSel;
  logic [DATA_W-1:0] rawIntr;
  logic              davFlag;
  logic              txPending;

  serRegCtrl uCtrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busWord (busWord),
    .busAddr (busAddr),
    .rxValid (rxValid),
    .rxReady (rxReady),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  serRegData uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .busWdata (busWdata),
    .rxData   (rxData),
    .busRdata (busRdata),
    .txValid  (txValid),
    .txData   (txData),
    .rxReady  (rxReady),
    .irq      (irq),
    .rawIntr  (rawIntr),
    .davFlag  (davFlag),
    .txPending(txPending)
  );
endmodule

// File: rtl/serRegChk.sv
module serRegChk
  import serRegPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic              busWord,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              txValid,
  input logic [BYTE_W-1:0] txData,
  input logic              rxValid,
  input logic              rxReady,
  input logic              irq,
  input logic [DATA_W-1:0] rawIntr,
  input logic              davFlag,
  input logic              txPending
);
  logic wordWr, wordRd, rxTake;
  assign wordWr = busSel & busWrite & busWord;
  assign wordRd = busSel & ~busWrite & busWord;
  assign rxTake = rxValid & rxReady;

  // R1: transmitter flags visible in every status read
  a_r1_tx_flags: assert property (@(posedge clk) disable iff (!rstN)
    (wordRd && busAddr == OFF_STAT_OBS) |-> (busRdata[TX_RDY_BIT] && busRdata[TX_IDLE_BIT]));

  // R3: data-out write produces the pulse, raw bit 0 and pending mark
  a_r3_dout_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (wordWr && busAddr == OFF_DOUT) |=>
      (txValid && txData == $past(busWdata[BYTE_W-1:0]) && rawIntr[TX_INT_BIT] && txPending));

  // R3: no pulse without a data-out write
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !(wordWr && busAddr == OFF_DOUT) |=> !txValid);

  // R4: clearing read drops data-available when no byte arrives
  a_r4_clear_dav: assert property (@(posedge clk) disable iff (!rstN)
    (wordRd && busAddr == OFF_STAT_CLR && !rxTake) |=> !davFlag);

  // R5, R11: accepted byte always leaves data-available and raw bit 3 set
  a_r5_capture: assert property (@(posedge clk) disable iff (!rstN)
    rxTake |=> (davFlag && rawIntr[RX_INT_BIT]));

  // R5: receive path open whenever raw bit 3 is clear
  a_r5_ready: assert property (@(posedge clk) disable iff (!rstN)
    !rawIntr[RX_INT_BIT] |-> rxReady);

  // R7: pending transmit re-arms bit 0 on acknowledge
  a_r7_rearm: assert property (@(posedge clk) disable iff (!rstN)
    (wordWr && busAddr == OFF_ACK && busWdata[TX_INT_BIT] && txPending) |=>
      (rawIntr[TX_INT_BIT] && !txPending));

  // R8: interrupt only with some raw bit set
  a_r8_irq_src: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rawIntr != '0));

  // R9: byte reads return zero
  a_r9_byte_read: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && !busWord) |-> (busRdata == '0));
endmodule

bind serRegFront serRegChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busWord  (busWord),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .txValid  (txValid),
  .txData   (txData),
  .rxValid  (rxValid),
  .rxReady  (rxReady),
  .irq      (irq),
  .rawIntr  (rawIntr),
  .davFlag  (davFlag),
  .txPending(txPending)
);

// File: tb/serRegFront_test.sv
`timescale 1ns/1ps
module serRegFront_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0, busWord = 1'b1;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txValid;
  logic [7:0]  txData;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxReady;
  logic        irq;

  int checkCnt = 0;
  int failCnt  = 0;

  localparam logic [31:0] STAT_BASE = 32'h0140_0000;
  localparam logic [31:0] DAV       = 32'h0001_0000;

  always #2.5 clk = ~clk;

  serRegFront uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busWord(busWord),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txValid(txValid), .txData(txData), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic word = 1'b1);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busWord = word; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWord = 1'b1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic word = 1'b1);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busWord = word; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0; busWord = 1'b1;
  endtask

  task automatic sendRx(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic tReset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 txValid", {31'b0, txValid}, 32'h0);
    check("R1 rxReady", {31'b0, rxReady}, 32'h1);
    rd(12'h024, v); check("R1 status", v, STAT_BASE);
    rd(12'h034, v); check("R1 raw", v, 32'h0);
    rd(12'h038, v); check("R1 masked", v, 32'h0);
  endtask

  task automatic tRegs();
    logic [31:0] v;
    wr(12'h000, 32'hA5A5_0001); rd(12'h000, v); check("R2 txctrl", v, 32'hA5A5_0001);
    wr(12'h004, 32'h0000_0003); rd(12'h004, v); check("R2 dmaen", v, 32'h3);
    wr(12'h008, 32'h0000_0000); rd(12'h008, v); check("R2 recctrl", v, 32'h0);
    wr(12'h02C, 32'h0000_0000); rd(12'h02C, v); check("R2 mask", v, 32'h0);
    rd(12'h01C, v); check("R10 dout read", v, 32'h0);
    rd(12'h03C, v); check("R10 unmapped read", v, 32'h0);
    wr(12'h034, 32'hFFFF_FFFF); wr(12'h038, 32'hFFFF_FFFF);
    wr(12'h024, 32'hFFFF_FFFF); wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h034, v); check("R10 raw unchanged", v, 32'h0);
    rd(12'h024, v); check("R10 status unchanged", v, STAT_BASE);
    check("R10 rxReady", {31'b0, rxReady}, 32'h1);
  endtask

  task automatic tTransmit();
    logic [31:0] v;
    wr(12'h01C, 32'h1234_56C3);
    check("R3 txValid", {31'b0, txValid}, 32'h1);
    check("R3 txData", {24'b0, txData}, 32'hC3);
    @(negedge clk);
    check("R3 pulse ends", {31'b0, txValid}, 32'h0);
    rd(12'h034, v); check("R3 raw bit0", v, 32'h1);
  endtask

  task automatic tPending();
    logic [31:0] v;
    wr(12'h030, 32'h1);
    rd(12'h034, v); check("R7 rearm", v, 32'h1);
    wr(12'h030, 32'h1);
    rd(12'h034, v); check("R7 second ack clears", v, 32'h0);
    rd(12'h030, v); check("R6 ack reads zero", v, 32'h0);
  endtask

  task automatic tReceive();
    logic [31:0] v;
    sendRx(8'h5A);
    rd(12'h024, v); check("R5 capture", v, STAT_BASE | DAV | 32'h5A);
    rd(12'h034, v); check("R5 raw bit3", v, 32'h8);
    check("R5 ready low", {31'b0, rxReady}, 32'h0);
    rd(12'h020, v); check("R4 clearing read value", v, STAT_BASE | DAV | 32'h5A);
    rd(12'h024, v); check("R4 dav cleared", v, STAT_BASE | 32'h5A);
    rd(12'h024, v); check("R4 observe no effect", v, STAT_BASE | 32'h5A);
    sendRx(8'h77);
    rd(12'h024, v); check("R5 blocked byte ignored", v, STAT_BASE | 32'h5A);
    wr(12'h008, 32'h1);
    check("R5 ready via recctrl", {31'b0, rxReady}, 32'h1);
    sendRx(8'h77);
    rd(12'h024, v); check("R5 enabled capture", v, STAT_BASE | DAV | 32'h77);
    wr(12'h008, 32'h0);
    wr(12'h030, 32'h8);
    rd(12'h034, v); check("R6 ack clears bit3", v, 32'h0);
    check("R5 ready after ack", {31'b0, rxReady}, 32'h1);
  endtask

  task automatic tIrq();
    logic [31:0] v;
    wr(12'h02C, 32'h9);
    check("R8 irq low no raw", {31'b0, irq}, 32'h0);
    sendRx(8'h11);
    check("R8 irq high", {31'b0, irq}, 32'h1);
    rd(12'h038, v); check("R8 masked", v, 32'h8);
    wr(12'h02C, 32'h1);
    check("R8 irq masked off", {31'b0, irq}, 32'h0);
    rd(12'h038, v); check("R8 masked zero", v, 32'h0);
    wr(12'h030, 32'h8);
    wr(12'h02C, 32'h0);
  endtask

  task automatic tByte();
    logic [31:0] v;
    wr(12'h02C, 32'h1);
    rd(12'h02C, v, 1'b0); check("R9 byte read", v, 32'h0);
    wr(12'h02C, 32'hF, 1'b0);
    rd(12'h02C, v); check("R9 byte write ignored", v, 32'h1);
    wr(12'h01C, 32'h55, 1'b0);
    check("R9 no tx byte", {31'b0, txValid}, 32'h0);
    rd(12'h034, v); check("R9 raw untouched", v, 32'h0);
    wr(12'h02C, 32'h0);
  endtask

  task automatic tCollide();
    logic [31:0] v;
    // byte arrives together with the clearing status read
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busWord = 1'b1; busAddr = 12'h020;
    rxValid = 1'b1; rxData = 8'h3C;
    @(negedge clk);
    busSel = 1'b0; rxValid = 1'b0;
    rd(12'h024, v); check("R11 rx beats clearing read", v, STAT_BASE | DAV | 32'h3C);
    // byte arrives together with acknowledge of bit 3
    wr(12'h008, 32'h1);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busWord = 1'b1; busAddr = 12'h030; busWdata = 32'h8;
    rxValid = 1'b1; rxData = 8'hE1;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; rxValid = 1'b0;
    rd(12'h034, v); check("R11 rx beats ack", v, 32'h8);
    rd(12'h024, v); check("R11 byte stored", v, STAT_BASE | DAV | 32'hE1);
  endtask

  initial begin
    #200000;
    failCnt++; checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRegs();
    tTransmit();
    tPending();
    tReceive();
    tIrq();
    tByte();
    tCollide();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule